// File: doc/BRIEF.md
# Request/Response Link Handshake Checker

This block is a passive monitor for a two-channel link in which an initiator sends requests on one channel and a target returns responses on the other. Each channel carries a valid, a ready and a payload, and a transfer happens only in a cycle where valid and ready are both high. The monitor drives nothing onto the link. It checks the handshake rules on both channels, checks that a request carrying an atomic or reservation opcode does not also set the write bit, and tracks how many accepted requests still wait for a response.

The link is strictly ordered, so each response belongs to the oldest accepted request that is still open. The monitor therefore keeps an outstanding count and a wait timer. It flags a response that has no open request, a request that would push the count past its configured limit, and an open request that waits too long for a response. Each rule has its own bit in a sticky violation code, and the code stays set until reset. A summary error output is high whenever any code bit is set.

The monitor is meant to stay in simulation and emulation builds of a larger system. An integrator ties its inputs to the link signals and watches the error output.

Top module: `link_hs_checker`

## Requirements
- R1: During synchronous active-high reset, and in the first cycle after reset, errCode and outstanding read 0 and errAny is low. Stimulus applied while reset is high records no violation.
- R2: If reqValid is high without reqReady in one cycle and reqValid is low in the next, bit 0 of errCode sets.
- R3: If a request is pending (valid without ready) and the next cycle shows any change in {reqOp, reqWrite, reqPayload}, bit 1 sets. A payload change after the handshake cycle is allowed.
- R4: The response channel follows the same rules: valid dropping before the handshake sets bit 2, and a change in rspPayload while pending sets bit 3.
- R5: outstanding rises by one for each accepted request and falls by one for each matched response. The new value is visible in the cycle after the handshake. A valid without ready changes nothing.
- R6: A response handshake in a cycle where outstanding is 0 sets bit 4, and outstanding stays 0.
- R7: An accepted request that finds outstanding at MAX_OUTSTANDING, with no matched response in the same cycle, sets bit 5, and outstanding holds at MAX_OUTSTANDING.
- R8: reqValid high with reqOp nonzero (atomic, load-reserve or store-conditional) and reqWrite high sets bit 6. reqOp equal to 0 marks a plain read or write, and then reqWrite may be 1.
- R9: If outstanding is nonzero and no response handshake occurs for TIMEOUT_CYCLES consecutive cycles, bit 7 sets after the last of those cycles. A response handshake restarts the count.
- R10: Code bits are sticky. A set bit stays set until reset, a violation shows in errCode in the cycle after it occurs, and errAny is high exactly when errCode is nonzero.
- R11: ready may toggle on either channel while valid is low without causing any violation or count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request channel valid |
| reqReady | input | 1 | Request channel ready |
| reqOp | input | OP_W | Request opcode, 0 = plain read/write, nonzero = atomic/LR/SC |
| reqWrite | input | 1 | Request write bit |
| reqPayload | input | REQ_W | Other request fields (address, data, strobes) |
| rspValid | input | 1 | Response channel valid |
| rspReady | input | 1 | Response channel ready |
| rspPayload | input | RSP_W | Response fields, including data and error bit |
| errAny | output | 1 | High when any violation has been recorded |
| errCode | output | 8 | Sticky per-rule violation bits (bit positions in R2 to R9) |
| outstanding | output | $clog2(MAX_OUTSTANDING+1) | Accepted requests still waiting for a response |

## Verification
Properties are checked on every cycle for these rules: valid dropping before a request handshake sets its bit, an illegal atomic write sets its bit, an unmatched response sets its bit, the count never exceeds its limit or rises without an accepted request, and no code bit ever clears outside reset. Other rules can only be shown by directed scenarios: the exact code value for each single violation, the limit cases of the count and the wait timer, the timer restarting on a response, and the absence of false flags under free ready toggling or stable stalls.

// File: rtl/lhc_pkg.sv
package lhc_pkg;
  localparam int CODE_W       = 8;
  localparam int BIT_REQ_DROP = 0;
  localparam int BIT_REQ_CHG  = 1;
  localparam int BIT_RSP_DROP = 2;
  localparam int BIT_RSP_CHG  = 3;
  localparam int BIT_ORPHAN   = 4;
  localparam int BIT_OVERFLOW = 5;
  localparam int BIT_AMO_WR   = 6;
  localparam int BIT_TIMEOUT  = 7;

  // Per-cycle event strobes from the datapath to the control.
  typedef struct packed {
    logic reqFire;
    logic rspFire;
    logic reqDrop;
    logic reqChange;
    logic rspDrop;
    logic rspChange;
    logic amoWrite;
  } evt_t;
endpackage

// File: rtl/lhc_hold_watch.sv
// Watches one valid/ready channel for a dropped valid or a changed payload
// while a transfer is pending.
module lhc_hold_watch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         ready,
  input  logic [W-1:0] bits,
  output logic         fire,
  output logic         dropHit,
  output logic         changeHit
);
  logic         pending;
  logic [W-1:0] heldBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      heldBits <= '0;
    end else begin
      pending  <= valid && !ready;
      heldBits <= bits;
    end
  end

  always_comb begin
    fire      = valid && ready;
    dropHit   = pending && !valid;
    changeHit = pending && valid && (bits != heldBits);
  end
endmodule

// File: rtl/lhc_datapath.sv
// Datapath: one hold watcher per channel plus the opcode/write decode.
module lhc_datapath import lhc_pkg::*; #(
  parameter int OP_W  = 4,
  parameter int REQ_W = 32,
  parameter int RSP_W = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqReady,
  input  logic [OP_W-1:0]  reqOp,
  input  logic             reqWrite,
  input  logic [REQ_W-1:0] reqPayload,
  input  logic             rspValid,
  input  logic             rspReady,
  input  logic [RSP_W-1:0] rspPayload,
  output evt_t             evt
);
  localparam int REQ_BITS = OP_W + 1 + REQ_W;

  logic [REQ_BITS-1:0] reqBits;
  logic reqFire, reqDrop, reqChange;
  logic rspFire, rspDrop, rspChange;

  assign reqBits = {reqOp, reqWrite, reqPayload};

  lhc_hold_watch #(.W(REQ_BITS)) reqWatch_i (
    .clk(clk), .rst(rst), .valid(reqValid), .ready(reqReady), .bits(reqBits),
    .fire(reqFire), .dropHit(reqDrop), .changeHit(reqChange)
  );

  lhc_hold_watch #(.W(RSP_W)) rspWatch_i (
    .clk(clk), .rst(rst), .valid(rspValid), .ready(rspReady), .bits(rspPayload),
    .fire(rspFire), .dropHit(rspDrop), .changeHit(rspChange)
  );

  always_comb begin
    evt.reqFire   = reqFire;
    evt.rspFire   = rspFire;
    evt.reqDrop   = reqDrop;
    evt.reqChange = reqChange;
    evt.rspDrop   = rspDrop;
    evt.rspChange = rspChange;
    evt.amoWrite  = reqValid && (reqOp != '0) && reqWrite;
  end
endmodule

// File: rtl/lhc_ctrl.sv
// Control: outstanding count, response wait timer, sticky violation code.
module lhc_ctrl import lhc_pkg::*; #(
  parameter int MAX_OUTSTANDING = 8,
  parameter int TIMEOUT_CYCLES  = 64,
  localparam int CNT_W  = $clog2(MAX_OUTSTANDING + 1),
  localparam int WAIT_W = $clog2(TIMEOUT_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  evt_t              evt,
  output logic [CNT_W-1:0]  outstanding,
  output logic [CODE_W-1:0] errCode
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(MAX_OUTSTANDING);
  localparam logic [WAIT_W-1:0] WAIT_LIM = WAIT_W'(TIMEOUT_CYCLES - 1);

  logic [WAIT_W-1:0] waitCnt, waitNext;
  logic [CNT_W-1:0]  countNext;
  logic [CODE_W-1:0] hits;
  logic rspMatched, orphan, overflow, reqAccept, waiting, timeoutHit;

  always_comb begin
    rspMatched = evt.rspFire && (outstanding != '0);
    orphan     = evt.rspFire && (outstanding == '0);
    overflow   = evt.reqFire && (outstanding == CNT_MAX) && !rspMatched;
    reqAccept  = evt.reqFire && !overflow;

    countNext = outstanding;
    if (reqAccept && !rspMatched)      countNext = outstanding + 1'b1;
    else if (!reqAccept && rspMatched) countNext = outstanding - 1'b1;

    waiting    = (outstanding != '0) && !evt.rspFire;
    timeoutHit = waiting && (waitCnt == WAIT_LIM);
    if (!waiting)        waitNext = '0;
    else if (timeoutHit) waitNext = waitCnt;
    else                 waitNext = waitCnt + 1'b1;

    hits               = '0;
    hits[BIT_REQ_DROP] = evt.reqDrop;
    hits[BIT_REQ_CHG]  = evt.reqChange;
    hits[BIT_RSP_DROP] = evt.rspDrop;
    hits[BIT_RSP_CHG]  = evt.rspChange;
    hits[BIT_ORPHAN]   = orphan;
    hits[BIT_OVERFLOW] = overflow;
    hits[BIT_AMO_WR]   = evt.amoWrite;
    hits[BIT_TIMEOUT]  = timeoutHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= '0;
      waitCnt     <= '0;
      errCode     <= '0;
    end else begin
      outstanding <= countNext;
      waitCnt     <= waitNext;
      errCode     <= errCode | hits;
    end
  end
endmodule

// File: rtl/link_hs_checker.sv
module link_hs_checker import lhc_pkg::*; #(
  parameter int OP_W            = 4,
  parameter int REQ_W           = 32,
  parameter int RSP_W           = 33,
  parameter int MAX_OUTSTANDING = 8,
  parameter int TIMEOUT_CYCLES  = 64,
  localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqReady,
  input  logic [OP_W-1:0]   reqOp,
  input  logic              reqWrite,
  input  logic [REQ_W-1:0]  reqPayload,
  input  logic              rspValid,
  input  logic              rspReady,
  input  logic [RSP_W-1:0]  rspPayload,
  output logic              errAny,
  output logic [CODE_W-1:0] errCode,
  output logic [CNT_W-1:0]  outstanding
);
  evt_t evt;

  lhc_datapath #(.OP_W(OP_W), .REQ_W(REQ_W), .RSP_W(RSP_W)) dp_i (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqWrite(reqWrite), .reqPayload(reqPayload),
    .rspValid(rspValid), .rspReady(rspReady), .rspPayload(rspPayload),
    .evt(evt)
  );

  lhc_ctrl #(.MAX_OUTSTANDING(MAX_OUTSTANDING), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctrl_i (
    .clk(clk), .rst(rst), .evt(evt),
    .outstanding(outstanding), .errCode(errCode)
  );

  assign errAny = |errCode;
endmodule

// File: rtl/link_hs_checker_sva.sv
module link_hs_checker_sva import lhc_pkg::*; #(
  parameter int OP_W            = 4,
  parameter int MAX_OUTSTANDING = 8,
  localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic [OP_W-1:0]   reqOp,
  input logic              reqWrite,
  input logic              rspValid,
  input logic              rspReady,
  input logic [CODE_W-1:0] errCode,
  input logic [CNT_W-1:0]  outstanding
);
  // High once the previous sampled cycle was out of reset.
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R2: request valid dropped while pending
  a_r2_req_drop: assert property (@(posedge clk) disable iff (rst)
    armed && $past(reqValid && !reqReady) && !reqValid |=> errCode[BIT_REQ_DROP]);

  // R5: count never rises without an accepted request
  a_r5_no_rise: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(reqValid && reqReady) |-> outstanding <= $past(outstanding));

  // R6: unmatched response is flagged
  a_r6_orphan: assert property (@(posedge clk) disable iff (rst)
    armed && $past(rspValid && rspReady && outstanding == '0) |-> errCode[BIT_ORPHAN]);

  // R7: count stays within its limit
  a_r7_bound: assert property (@(posedge clk) disable iff (rst)
    outstanding <= CNT_W'(MAX_OUTSTANDING));

  // R8: atomic opcode with write bit is flagged
  a_r8_amo_write: assert property (@(posedge clk) disable iff (rst)
    reqValid && (reqOp != '0) && reqWrite |=> errCode[BIT_AMO_WR]);

  // R10: no code bit clears outside reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    armed |-> (errCode & $past(errCode)) == $past(errCode));
endmodule

bind link_hs_checker link_hs_checker_sva #(
  .OP_W(OP_W), .MAX_OUTSTANDING(MAX_OUTSTANDING)
) sva_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .reqOp(reqOp), .reqWrite(reqWrite), .rspValid(rspValid), .rspReady(rspReady),
  .errCode(errCode), .outstanding(outstanding)
);

// File: tb/link_hs_checker_tb_top.sv
`timescale 1ns/1ps
module link_hs_checker_tb_top;
  localparam int OP_W = 4, REQ_W = 32, RSP_W = 33;
  localparam int MAXO = 4, TMO = 16;
  localparam int CNT_W = $clog2(MAXO + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqReady = 1'b0, reqWrite = 1'b0;
  logic [OP_W-1:0]  reqOp = '0;
  logic [REQ_W-1:0] reqPayload = '0;
  logic rspValid = 1'b0, rspReady = 1'b0;
  logic [RSP_W-1:0] rspPayload = '0;
  logic errAny;
  logic [7:0] errCode;
  logic [CNT_W-1:0] outstanding;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  link_hs_checker #(.OP_W(OP_W), .REQ_W(REQ_W), .RSP_W(RSP_W),
                    .MAX_OUTSTANDING(MAXO), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqWrite(reqWrite), .reqPayload(reqPayload),
    .rspValid(rspValid), .rspReady(rspReady), .rspPayload(rspPayload),
    .errAny(errAny), .errCode(errCode), .outstanding(outstanding)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqReady = 0; reqWrite = 0; reqOp = '0;
    rspValid = 0; rspReady = 0;
  endtask

  task automatic doReset();
    rst = 1; idle(); step(2); rst = 0;
  endtask

  task automatic acceptReq(logic [31:0] pl);
    reqValid = 1; reqReady = 1; reqOp = '0; reqWrite = 0; reqPayload = pl;
    step(); reqValid = 0; reqReady = 0;
  endtask

  task automatic acceptRsp(logic [32:0] pl);
    rspValid = 1; rspReady = 1; rspPayload = pl;
    step(); rspValid = 0; rspReady = 0;
  endtask

  task automatic t_reset();
    rst = 1; idle();
    reqValid = 1; step(); reqValid = 0; step();
    chk("R1 code in reset", {24'd0, errCode}, 32'h0);
    chk("R1 count in reset", 32'(outstanding), 32'd0);
    rst = 0; step();
    chk("R1 code after reset", {24'd0, errCode}, 32'h0);
    chk("R1 errAny after reset", {31'd0, errAny}, 32'd0);
  endtask

  task automatic t_basic();
    doReset();
    reqValid = 1; reqReady = 0; reqPayload = 32'hA5A5_0001;
    step(); chk("R5 stall no count", 32'(outstanding), 32'd0);
    step(2); reqReady = 1; step();
    reqReady = 0; reqPayload = 32'h1234_5678; reqValid = 0; step();
    chk("R5 count after accept", 32'(outstanding), 32'd1);
    chk("R3 change after handshake ok", {24'd0, errCode}, 32'h0);
    acceptRsp(33'h0_0000_0042);
    chk("R5 count after response", 32'(outstanding), 32'd0);
    chk("R5 clean traffic code", {24'd0, errCode}, 32'h0);
  endtask

  task automatic t_ready_free();
    doReset();
    for (int i = 0; i < 6; i++) begin
      reqReady = i[0]; rspReady = ~i[0]; step();
    end
    idle(); step();
    chk("R11 ready toggling code", {24'd0, errCode}, 32'h0);
    chk("R11 ready toggling count", 32'(outstanding), 32'd0);
  endtask

  task automatic t_req_rules();
    doReset();
    reqValid = 1; reqReady = 0; step(); reqValid = 0; step();
    chk("R2 req valid drop", {24'd0, errCode}, 32'h01);
    doReset();
    reqValid = 1; reqReady = 0; reqWrite = 0; step(); reqWrite = 1; step();
    chk("R3 req payload change", {24'd0, errCode}, 32'h02);
  endtask

  task automatic t_rsp_rules();
    doReset(); acceptReq(32'h10);
    rspValid = 1; rspReady = 0; step(); rspValid = 0; step();
    chk("R4 rsp valid drop", {24'd0, errCode}, 32'h04);
    doReset(); acceptReq(32'h11);
    rspValid = 1; rspReady = 0; rspPayload = 33'h1; step();
    rspPayload = 33'h1_0000_0001; step();
    chk("R4 rsp payload change", {24'd0, errCode}, 32'h08);
  endtask

  task automatic t_orphan();
    doReset();
    acceptRsp(33'h5);
    chk("R6 orphan code", {24'd0, errCode}, 32'h10);
    chk("R6 orphan count", 32'(outstanding), 32'd0);
  endtask

  task automatic t_overflow();
    doReset();
    for (int i = 0; i < MAXO; i++) acceptReq(32'(i));
    chk("R7 count at limit", 32'(outstanding), 32'(MAXO));
    chk("R7 no flag at limit", {24'd0, errCode}, 32'h0);
    acceptReq(32'hFF);
    chk("R7 overflow code", {24'd0, errCode}, 32'h20);
    chk("R7 count held", 32'(outstanding), 32'(MAXO));
    for (int i = 0; i < MAXO; i++) acceptRsp(33'(i));
    chk("R7 drained count", 32'(outstanding), 32'd0);
    chk("R10 code kept after drain", {24'd0, errCode}, 32'h20);
  endtask

  task automatic t_amo();
    doReset();
    reqValid = 1; reqReady = 1; reqOp = '0; reqWrite = 1; step();
    reqOp = 4'd3; reqWrite = 0; step();
    idle(); step();
    chk("R8 plain write and atomic read ok", {24'd0, errCode}, 32'h0);
    reqValid = 1; reqReady = 1; reqOp = 4'd3; reqWrite = 1; step();
    idle(); step();
    chk("R8 atomic with write", {24'd0, errCode}, 32'h40);
  endtask

  task automatic t_timeout();
    doReset();
    acceptReq(32'h77);
    step(TMO - 1);
    chk("R9 no timeout before limit", {24'd0, errCode}, 32'h0);
    step();
    chk("R9 timeout at limit", {24'd0, errCode}, 32'h80);
    doReset();
    acceptReq(32'h1); acceptReq(32'h2);
    step(12); acceptRsp(33'h1); step(12);
    chk("R9 response restarts timer", {24'd0, errCode}, 32'h0);
  endtask

  task automatic t_sticky();
    doReset();
    reqValid = 1; reqReady = 0; step(); reqValid = 0; step();
    for (int i = 0; i < 3; i++) begin acceptReq(32'(i)); acceptRsp(33'(i)); end
    chk("R10 sticky code", {24'd0, errCode}, 32'h01);
    chk("R10 errAny set", {31'd0, errAny}, 32'd1);
    doReset(); step();
    chk("R10 reset clears", {24'd0, errCode}, 32'h0);
  endtask

  initial begin
    step();
    t_reset();
    t_basic();
    t_ready_free();
    t_req_rules();
    t_rsp_rules();
    t_orphan();
    t_overflow();
    t_amo();
    t_timeout();
    t_sticky();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule